// File: doc/BRIEF.md
# Serial-Configured Dual-Bank Bias Control Register

This block is a two-wire serial slave for a digitally adjusted bias supply. A bus master addresses it and then writes one configuration byte. The top bit of that byte picks one of two control banks: the operating bank or the suspend bank. The next two bits land in the chosen bank. The low five bits always load a converter code that both banks share. A read returns one status byte. It carries a power-good flag and the current converter code.

Each bank holds a run-control bit and a display-enable bit. An external bank-pick pin selects which bank drives the run and display outputs, so the system can preload suspend settings and switch to them with a single pin. The power-good comparator, the converter and the regulator lie outside this block. Power-good enters only as a digital level.

The bus lines are sampled with the system clock. That clock must be fast enough to see every SCL phase for several cycles. SDA is driven as an open-drain pull-down enable.

Top module: `bias_cfg_slave`

## Requirements
- R1: Bit 7 of a written configuration byte routes bits 6 and 5 into the operating bank when it is 1, and into the suspend bank when it is 0. The other bank keeps its contents.
- R2: Inside the selected bank, bit 6 is the run-control bit (1 = running, 0 = shut down) and bit 5 is the display-enable bit (1 = on, 0 = off).
- R3: Bits 4..0 of every written configuration byte load the 5-bit converter code (bit 4 is the MSB), whatever the value of bit 7.
- R4: With `bank_pick` high, `run_out` and `disp_out` come from the operating bank. With `bank_pick` low, they come from the suspend bank.
- R5: After reset, both banks hold run = 1 and display = 1, and the converter code is 0.
- R6: A read returns one byte, MSB first. Bit 7 is the power-good status, bits 6 and 5 read 0, and bits 4..0 are the converter code.
- R7: The power-good status bit is 1 only when `pgood_in` is high and `run_out` is 1. Otherwise it is 0.
- R8: The 7-bit address is compared with parameter `SLAVE_ADDR` (default 7'h2C), followed by the R/W bit (0 = write, 1 = read). When the address does not match, the slave gives no ACK and leaves SDA released until the next START.
- R9: The slave pulls SDA low during the ACK clock after a matching address byte and after each written data byte. `sda_oe` changes only while SCL is low.
- R10: The registers change only at the ACK of a complete 8-bit data byte. A STOP or a repeated START inside a byte leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| bank_pick | input | 1 | 1 = operating bank drives the outputs, 0 = suspend bank |
| pgood_in | input | 1 | Digital power-good level from the external comparator |
| run_out | output | 1 | Run control from the live bank (0 = shut down) |
| disp_out | output | 1 | Display enable from the live bank |

## Verification
Writes go to both banks with differing bit 6, bit 5 and code patterns. Toggling `bank_pick` between them shows whether the routing is right, or whether the bank selection is inverted or the run and display bits are swapped. Reads taken with power-good high and low, while the live bank is running and while it is shut down, separate the AND condition from either input alone. A write that zeroes the code through the suspend bank while the operating bank is live shows that the code loads regardless of bank. A wrong address, a STOP after four data bits and a repeated START inside a byte must all leave the outputs and the read-back code untouched. A complete write sent right after the repeated START must still take effect.

// File: rtl/bias_cfg_pkg.sv
// Shared widths, link states and the bank record for the bias control slave.
package bias_cfg_pkg;
    localparam int BYTE_W = 8;
    localparam int DAC_W  = 5;
    localparam int ADR_W  = 7;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WBYTE,
        ST_WACK,
        ST_RBYTE,
        ST_SKIP
    } link_st_e;

    typedef struct packed {
        logic run;
        logic disp;
    } bank_t;
endpackage

// File: rtl/bias_bus_sampler.sv
// Synchronises SCL/SDA into the clk domain and flags SCL edges, START and STOP.
// Assumes SYNC_STAGES >= 2 and each SCL phase lasts several clk cycles.
module bias_bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_d;
    logic                   sda_d;

    // Shift both lines through the synchroniser and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
            scl_d  <= scl_sh[SYNC_STAGES-1];
            sda_d  <= sda_sh[SYNC_STAGES-1];
        end
    end

    // Decode edges and bus conditions from current and previous levels.
    always_comb begin
        scl_lvl   = scl_sh[SYNC_STAGES-1];
        sda_lvl   = sda_sh[SYNC_STAGES-1];
        scl_rise  = scl_lvl & ~scl_d;
        scl_fall  = ~scl_lvl & scl_d;
        start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
        stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
    end
endmodule

// File: rtl/bias_link_engine.sv
// Byte-level slave protocol: address match, write shifting, ACK and read-out.
// Assumes inputs come from bias_bus_sampler; sda_drv = 1 means pull SDA low.
module bias_link_engine
    import bias_cfg_pkg::*;
#(
    parameter logic [ADR_W-1:0] SLAVE_ADDR = 7'h2C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] status_byte,
    output logic              sda_drv,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_byte
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    link_st_e          st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] tx;
    logic              rw;
    logic              ack_on;
    logic [BYTE_W-1:0] sh_next;

    // Next shift value with the bit sampled on this SCL rise.
    always_comb sh_next = {sh[BYTE_W-2:0], sda_lvl};

    assign wr_byte = sh;

    // Protocol state machine, advanced by SCL edges and bus conditions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            sh      <= '0;
            tx      <= '0;
            rw      <= 1'b0;
            ack_on  <= 1'b0;
            sda_drv <= 1'b0;
            wr_en   <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (stop_det) begin
                st      <= ST_IDLE;
                sda_drv <= 1'b0;
                ack_on  <= 1'b0;
            end else if (start_det) begin
                st      <= ST_ADDR;
                cnt     <= '0;
                sda_drv <= 1'b0;
                ack_on  <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR: if (scl_rise) begin
                        sh  <= sh_next;
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST_BIT) begin
                            rw <= sh_next[0];
                            st <= (sh_next[BYTE_W-1:1] == SLAVE_ADDR) ? ST_AACK : ST_SKIP;
                        end
                    end
                    ST_AACK: if (scl_fall) begin
                        if (!ack_on) begin
                            ack_on  <= 1'b1;
                            sda_drv <= 1'b1;
                        end else begin
                            ack_on <= 1'b0;
                            cnt    <= '0;
                            if (rw) begin
                                st      <= ST_RBYTE;
                                tx      <= status_byte;
                                sda_drv <= ~status_byte[BYTE_W-1];
                            end else begin
                                st      <= ST_WBYTE;
                                sda_drv <= 1'b0;
                            end
                        end
                    end
                    ST_WBYTE: if (scl_rise) begin
                        sh  <= sh_next;
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST_BIT) st <= ST_WACK;
                    end
                    ST_WACK: begin
                        if (scl_rise && ack_on) wr_en <= 1'b1;
                        if (scl_fall) begin
                            if (!ack_on) begin
                                ack_on  <= 1'b1;
                                sda_drv <= 1'b1;
                            end else begin
                                ack_on  <= 1'b0;
                                sda_drv <= 1'b0;
                                cnt     <= '0;
                                st      <= ST_WBYTE;
                            end
                        end
                    end
                    ST_RBYTE: if (scl_fall) begin
                        cnt <= cnt + 1'b1;
                        tx  <= {tx[BYTE_W-2:0], 1'b0};
                        if (cnt == LAST_BIT) begin
                            sda_drv <= 1'b0;
                            st      <= ST_SKIP;
                        end else begin
                            sda_drv <= ~tx[BYTE_W-2];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/bias_cfg_regs.sv
// Holds the two control banks and the shared converter code; picks the live bank.
// Assumes wr_en is a one-cycle pulse with wr_byte stable in that cycle.
module bias_cfg_regs
    import bias_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              bank_pick,
    output bank_t             op_bank,
    output bank_t             sus_bank,
    output logic [DAC_W-1:0]  dac_q,
    output logic              run_out,
    output logic              disp_out
);
    // Load the selected bank and the shared code on a committed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_bank  <= '{run: 1'b1, disp: 1'b1};
            sus_bank <= '{run: 1'b1, disp: 1'b1};
            dac_q    <= '0;
        end else if (wr_en) begin
            dac_q <= wr_byte[DAC_W-1:0];
            if (wr_byte[BYTE_W-1]) op_bank  <= '{run: wr_byte[6], disp: wr_byte[5]};
            else                   sus_bank <= '{run: wr_byte[6], disp: wr_byte[5]};
        end
    end

    // Route the bank chosen by the pin to the outputs.
    always_comb begin
        run_out  = bank_pick ? op_bank.run  : sus_bank.run;
        disp_out = bank_pick ? op_bank.disp : sus_bank.disp;
    end
endmodule

// File: rtl/bias_cfg_slave.sv
// Top of the serial-configured dual-bank bias control register.
// Assumes clk oversamples SCL by several cycles per phase.
module bias_cfg_slave
    import bias_cfg_pkg::*;
#(
    parameter logic [ADR_W-1:0] SLAVE_ADDR  = 7'h2C,
    parameter int               SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe,
    input  logic bank_pick,
    input  logic pgood_in,
    output logic run_out,
    output logic disp_out
);
    localparam int PAD_W = BYTE_W - 1 - DAC_W;

    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_byte;
    logic [BYTE_W-1:0] status_byte;
    logic [DAC_W-1:0]  dac_q;
    bank_t             op_bank, sus_bank;

    bias_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    bias_link_engine #(.SLAVE_ADDR(SLAVE_ADDR)) u_link (
        .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .status_byte(status_byte), .sda_drv(sda_oe), .wr_en(wr_en),
        .wr_byte(wr_byte)
    );

    bias_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte),
        .bank_pick(bank_pick), .op_bank(op_bank), .sus_bank(sus_bank),
        .dac_q(dac_q), .run_out(run_out), .disp_out(disp_out)
    );

    // Assemble the read-back byte: power-good, zero pad, converter code.
    always_comb status_byte = {pgood_in & run_out, {PAD_W{1'b0}}, dac_q};
endmodule

// File: rtl/bias_cfg_checker.sv
// Temporal checks on the bias control slave, attached by bind.
module bias_cfg_checker
    import bias_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_lvl,
    input logic              sda_oe,
    input logic              start_det,
    input logic              wr_en,
    input logic [BYTE_W-1:0] wr_byte,
    input logic [DAC_W-1:0]  dac_q,
    input bank_t             op_bank,
    input bank_t             sus_bank
);
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl); // R9
    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe); // R8
    AST_CODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (dac_q == $past(wr_byte[DAC_W-1:0]))); // R3
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(dac_q)); // R10
    AST_SUS_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_byte[BYTE_W-1]) |=> $stable(sus_bank)); // R1
    AST_OP_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_byte[BYTE_W-1]) |=> $stable(op_bank)); // R1
endmodule

bind bias_cfg_slave bias_cfg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_oe(sda_oe),
    .start_det(start_det), .wr_en(wr_en), .wr_byte(wr_byte),
    .dac_q(dac_q), .op_bank(op_bank), .sus_bank(sus_bank)
);

// File: tb/test_bias_cfg_slave.sv
// Bench for bias_cfg_slave: behavioural bus master plus a bank/code model
// compared with the outputs on every clock while no commit is pending.
module test_bias_cfg_slave;
    localparam int Q    = 10;
    localparam int ADDR = 7'h2C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic bank_pick = 1'b1;
    logic pgood_in = 1'b1;
    logic sda_oe, run_out, disp_out;
    logic sda_line;

    int checks = 0;
    int failures = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;

    // Reference state of the banks and code.
    int m_op_run = 1, m_op_disp = 1, m_sus_run = 1, m_sus_disp = 1, m_code = 0;

    assign sda_line = m_sda & ~sda_oe;

    always #10 clk = ~clk;

    bias_cfg_slave i_bias_cfg_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .bank_pick(bank_pick), .pgood_in(pgood_in),
        .run_out(run_out), .disp_out(disp_out)
    );

    function automatic int exp_run();
        return bank_pick ? m_op_run : m_sus_run;
    endfunction

    function automatic int exp_disp();
        return bank_pick ? m_op_disp : m_sus_disp;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison of the live outputs with the model.
    always @(negedge clk) begin
        if (chk_en && rst_n) begin
            check("R4 live run output", int'(run_out), exp_run());
            check("R4 live display output", int'(disp_out), exp_disp());
        end
    end

    task automatic wq();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic clock_bit(input logic b, output logic seen);
        m_sda = b;    wq();
        m_scl = 1'b1; wq();
        seen = sda_line;
        wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
    endtask

    task automatic write_cfg(input int adr, input logic [7:0] v, input bit match);
        logic ack;
        bus_start();
        send_byte({adr[6:0], 1'b0});
        clock_bit(1'b1, ack);
        check(match ? "R9 address ACK" : "R8 no ACK on wrong address", int'(!ack), int'(match));
        send_byte(v);
        chk_en = 1'b0;
        clock_bit(1'b1, ack);
        check(match ? "R9 data ACK" : "R8 stays released", int'(!ack), int'(match));
        if (match) begin
            m_code = int'(v[4:0]);
            if (v[7]) begin m_op_run = v[6]; m_op_disp = v[5]; end
            else      begin m_sus_run = v[6]; m_sus_disp = v[5]; end
        end
        chk_en = 1'b1;
        bus_stop();
    endtask

    task automatic read_status(output logic [7:0] v);
        logic ack;
        logic s;
        bus_start();
        send_byte({ADDR[6:0], 1'b1});
        clock_bit(1'b1, ack);
        check("R9 read address ACK", int'(!ack), 1);
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            v[i] = s;
        end
        clock_bit(1'b1, s);
        bus_stop();
    endtask

    function automatic int exp_status();
        return ((pgood_in && exp_run() == 1) ? 128 : 0) + m_code;
    endfunction

    initial begin
        logic [7:0] rb;
        logic s;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        wq();
        check("R5 reset run", int'(run_out), 1);
        check("R5 reset display", int'(disp_out), 1);
        chk_en = 1'b1;
        read_status(rb);
        check("R5 R6 R7 reset status", int'(rb), 8'h80);

        // R1 R2: operating bank gets run=0, display=1, code 10101.
        write_cfg(ADDR, 8'hB5, 1'b1);
        check("R2 operating run bit", int'(run_out), 0);
        check("R2 operating display bit", int'(disp_out), 1);
        read_status(rb);
        check("R6 R7 status with shutdown", int'(rb), 8'h15);

        // R4: suspend bank still at defaults.
        bank_pick = 1'b0; wq();
        check("R4 suspend bank live", int'(run_out), 1);
        read_status(rb);
        check("R7 status with suspend live", int'(rb), 8'h95);

        // R1: suspend write leaves operating bank intact.
        write_cfg(ADDR, 8'h43, 1'b1);
        check("R1 suspend display bit", int'(disp_out), 0);
        bank_pick = 1'b1; wq();
        check("R1 operating bank kept", int'(run_out), 0);
        bank_pick = 1'b0; wq();
        pgood_in = 1'b0;
        read_status(rb);
        check("R7 power-good low", int'(rb), 8'h03);
        pgood_in = 1'b1;

        // R3: code loads through a suspend write while operating bank is live.
        bank_pick = 1'b1; wq();
        write_cfg(ADDR, 8'h60, 1'b1);
        read_status(rb);
        check("R3 code via suspend write", int'(rb), 8'h00);
        bank_pick = 1'b0; wq();
        check("R3 suspend bank updated", int'(run_out), 1);

        // R8: wrong address changes nothing.
        write_cfg(ADDR ^ 1, 8'h9F, 1'b0);
        read_status(rb);
        check("R8 wrong address ignored", int'(rb), 8'h80);

        // R10: STOP after four data bits.
        bus_start();
        send_byte({ADDR[6:0], 1'b0});
        clock_bit(1'b1, s);
        for (int i = 0; i < 4; i++) clock_bit(1'b0, s);
        bus_stop();
        read_status(rb);
        check("R10 STOP mid-byte", int'(rb), 8'h80);

        // R10: repeated START mid-byte, then a full write.
        bus_start();
        send_byte({ADDR[6:0], 1'b0});
        clock_bit(1'b1, s);
        for (int i = 0; i < 4; i++) clock_bit(1'b0, s);
        chk_en = 1'b0;
        wq();
        check("R10 repeated START keeps run", int'(run_out), 1);
        chk_en = 1'b1;
        write_cfg(ADDR, 8'hE1, 1'b1);
        bank_pick = 1'b1; wq();
        check("R10 write after restart run", int'(run_out), 1);
        check("R10 write after restart display", int'(disp_out), 1);
        read_status(rb);
        check("R6 final status", int'(rb), 8'h81);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R9 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule